// File: doc/BRIEF.md
# SDRAM Auto-Refresh Timer and Sequencer

This block keeps a synchronous DRAM refreshed without help from software. A prescaler divides the system clock by a ratio chosen through a 3-bit clock-select code. Each prescaled tick advances an 8-bit interval counter. When the counter equals a programmable compare value on a tick, the counter returns to zero and keeps counting, and a refresh request is raised.

A request waits until the external bus reports that no access is in progress. It then runs a fixed four-cycle command burst on the SDRAM control pins: precharge-all, auto-refresh, and two no-operation recovery cycles. A busy flag tells the external bus arbiter to start no other access. The flag stays high from the moment a request is raised until the last recovery cycle has ended.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: While `refresh_en` is 0 no new refresh request is raised, and the interval counter and the prescaler are held at zero.
- R2: `clk_sel` codes 1 to 7 divide the system clock by 2, 8, 32, 128, 512, 2048 and 4096. Code 0 stops the prescaler and holds the interval counter at its value. While the code is 0 the prescaler phase is cleared, so on resuming at code 1 the next request comes one cycle later than the stopped time alone would explain.
- R3: On a prescaled tick where the counter equals `cmp_value` (C), a request is raised and the counter clears, so requests repeat every (C+1)×divisor cycles. After `refresh_en` rises with both counters at zero, the first precharge-all appears (C+1)×divisor+1 cycles later.
- R4: A refresh burst is exactly four consecutive cycles in the order precharge-all, auto-refresh, NOP, NOP, and at least one idle cycle follows it before another burst.
- R5: The command encoding on {`ras_n`,`cas_n`,`we_n`} is 010 for precharge-all, 001 for auto-refresh and 111 for NOP. NOP is driven in both recovery cycles and in idle. `prechg_sel` is 1 only during precharge-all.
- R6: `cke` is 1 at all times, including throughout every burst.
- R7: `refresh_busy` is 1 from the cycle after a request is raised through the second recovery cycle. It is 0 in idle when no request is pending.
- R8: A pending request starts a burst only when `bus_idle` is sampled 1. While `bus_idle` is 0 the request waits and no command other than NOP is driven.
- R9: Any number of requests raised while one is still pending produce a single burst. A pending request still runs after `refresh_en` falls.
- R10: After reset the pins show NOP, `prechg_sel` is 0, `cke` is 1 and `refresh_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_en | input | 1 | Enables periodic refresh requests |
| clk_sel | input | 3 | Prescaler divide code, 0 stops counting |
| cmp_value | input | 8 | Compare constant for the interval counter |
| bus_idle | input | 1 | High when no external access is in progress |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| cke | output | 1 | SDRAM clock enable, held high |
| prechg_sel | output | 1 | Address bit that selects all banks for precharge |
| refresh_busy | output | 1 | Holds off other external accesses |

## Verification
Two functions can fall in the same cycle: a new compare match can arrive while an earlier request is still pending or a burst is still running. The bench holds `bus_idle` low with a compare value of 0 and a divide of 2, so matches arrive every other cycle and pile up on one pending request. It then releases the bus and drops `refresh_en` in the same cycle. The result passes only if exactly one burst follows, with the correct command order, and no further precharge-all appears over the next forty cycles.

// File: rtl/sdram_refresh_pkg.sv
// Shared types and helpers for the SDRAM refresh block.
// Assumes a 3-bit clock-select code; code 0 means stopped.
package sdram_refresh_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRP,
        ST_TRR,
        ST_TRC1,
        ST_TRC2
    } rf_state_t;

    // Map a clock-select code to log2 of its divide ratio (0 = stopped)
    function automatic int sel_to_shift(input int code);
        case (code)
            1:       return 1;
            2:       return 3;
            3:       return 5;
            4:       return 7;
            5:       return 9;
            6:       return 11;
            7:       return 12;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/refresh_prescaler.sv
// Free-running prescaler that emits a one-cycle tick every 2^k clocks,
// where k is picked by the clock-select code. It is cleared while not
// running, so the phase restarts whenever counting resumes.
// Assumes PRESC_W is at least the largest shift in the package table.
module refresh_prescaler
    import sdram_refresh_pkg::*;
#(
    parameter int PRESC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int NCODES = 1 << SEL_W;

    logic [PRESC_W-1:0] pcnt;
    logic [NCODES-1:0]  code_hit;

    // Prescale count: advances while running, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    assign code_hit[0] = 1'b0;

    // One terminal-count detector per divide code
    generate
        for (genvar g = 1; g < NCODES; g++) begin : g_code
            localparam int SH = sel_to_shift(g);
            assign code_hit[g] = &pcnt[SH-1:0];
        end
    endgenerate

    assign tick = run && code_hit[sel];

endmodule

// File: rtl/refresh_timer.sv
// Interval counter: advances on each prescaled tick and, on a tick where it
// equals the compare value, flags a match and returns to zero.
// Assumes tick is low whenever counting is stopped.
module refresh_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic             match
);

    logic [CNT_W-1:0] cnt;

    assign match = enable && tick && (cnt == cmp);

    // Interval count: clear when disabled or on match, advance on tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!enable)
            cnt <= '0;
        else if (match)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/refresh_sequencer.sv
// Holds one pending refresh request and, once the bus is idle, walks the
// four-state burst precharge-all, auto-refresh, recovery, recovery.
// Assumes bus_idle stays low for as long as an external access runs.
module refresh_sequencer
    import sdram_refresh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic bus_idle,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic prechg_sel,
    output logic busy
);

    rf_state_t state, state_nx;
    logic      pending;
    logic      start;

    assign start = (state == ST_IDLE) && pending && bus_idle;

    // Pending flag: set by any match, cleared when a burst starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (match)
            pending <= 1'b1;
        else if (start)
            pending <= 1'b0;
    end

    // Next-state selection for the burst
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = ST_TRP;
            ST_TRP:  state_nx = ST_TRR;
            ST_TRR:  state_nx = ST_TRC1;
            ST_TRC1: state_nx = ST_TRC2;
            ST_TRC2: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Command decode from the registered state
    always_comb begin
        {ras_n, cas_n, we_n} = 3'b111;
        prechg_sel           = 1'b0;
        case (state)
            ST_TRP: begin
                {ras_n, cas_n, we_n} = 3'b010;
                prechg_sel           = 1'b1;
            end
            ST_TRR:  {ras_n, cas_n, we_n} = 3'b001;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end

    assign busy = pending || (state != ST_IDLE);

endmodule

// File: rtl/sdram_refresh_ctrl.sv
// Top of the SDRAM auto-refresh block: prescaler, interval timer and
// command sequencer. Register values arrive as static inputs.
// Assumes the caller meets the SDRAM refresh interval through cmp_value
// and clk_sel, and honours refresh_busy before starting an access.
module sdram_refresh_ctrl
    import sdram_refresh_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_en,
    input  logic [2:0]       clk_sel,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             bus_idle,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             cke,
    output logic             prechg_sel,
    output logic             refresh_busy
);

    logic run;
    logic tick;
    logic cmp_match;

    assign run = refresh_en && (clk_sel != '0);
    assign cke = 1'b1;

    refresh_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (clk_sel),
        .tick  (tick)
    );

    refresh_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (refresh_en),
        .tick   (tick),
        .cmp    (cmp_value),
        .match  (cmp_match)
    );

    refresh_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (cmp_match),
        .bus_idle   (bus_idle),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .prechg_sel (prechg_sel),
        .busy       (refresh_busy)
    );

endmodule

// File: rtl/sdram_refresh_chk.sv
// Protocol checker for the SDRAM refresh block, bound to the top module.
module sdram_refresh_chk (
    input logic clk,
    input logic rst_n,
    input logic refresh_en,
    input logic bus_idle,
    input logic match,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic prechg_sel,
    input logic busy
);

    logic is_pre, is_ref, is_nop;
    assign is_pre = !ras_n &&  cas_n && !we_n;
    assign is_ref = !ras_n && !cas_n &&  we_n;
    assign is_nop =  ras_n &&  cas_n &&  we_n;

    AST_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_en |-> !match); // R1

    AST_PRE_THEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> is_ref); // R4

    AST_REF_THEN_TWO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> is_nop ##1 is_nop); // R4

    AST_SEL_ONLY_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        prechg_sel |-> is_pre); // R5

    AST_CMD_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> busy); // R7

    AST_MATCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> busy); // R7

    AST_START_ON_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && $past(rst_n)) |-> $past(bus_idle)); // R8

endmodule

bind sdram_refresh_ctrl sdram_refresh_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh_en (refresh_en),
    .bus_idle   (bus_idle),
    .match      (cmp_match),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .prechg_sel (prechg_sel),
    .busy       (refresh_busy)
);

// File: tb/sdram_refresh_ctrl_tb.sv
module sdram_refresh_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_en = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic [7:0] cmp_value = 8'd0;
    logic       bus_idle = 1'b1;
    logic       ras_n, cas_n, we_n, cke, prechg_sel, refresh_busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // vector: {clk_sel, cmp_value, expected interval in cycles}
    localparam logic [26:0] VEC [0:7] = '{
        {3'd1, 8'd5,   16'd12},
        {3'd2, 8'd3,   16'd32},
        {3'd3, 8'd2,   16'd96},
        {3'd4, 8'd1,   16'd256},
        {3'd5, 8'd0,   16'd512},
        {3'd6, 8'd1,   16'd4096},
        {3'd7, 8'd0,   16'd4096},
        {3'd1, 8'd255, 16'd512}
    };

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_refresh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .clk_sel(clk_sel),
        .cmp_value(cmp_value), .bus_idle(bus_idle), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .prechg_sel(prechg_sel), .refresh_busy(refresh_busy)
    );

    function automatic int cmd();
        return {29'd0, ras_n, cas_n, we_n};
    endfunction

    function automatic bit is_pre();
        return cmd() == 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Wait for a precharge-all at a falling edge; returns its cycle or -1
    task automatic wait_pre(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (is_pre()) begin
                at = cyc;
                return;
            end
        end
    endtask

    // Called at the precharge-all falling edge; walks the rest of the burst
    task automatic check_burst();
        chk(prechg_sel == 1'b1, "R5 prechg_sel in precharge", prechg_sel, 1);
        chk(refresh_busy == 1'b1 && cke == 1'b1, "R7/R6 busy,cke in Trp", {refresh_busy, cke}, 3);
        @(negedge clk);
        chk(cmd() == 1 && !prechg_sel, "R4 R5 auto-refresh cmd", cmd(), 1);
        chk(refresh_busy && cke, "R7 R6 busy,cke in Trr", {refresh_busy, cke}, 3);
        @(negedge clk);
        chk(cmd() == 7 && refresh_busy, "R4 R7 NOP in Trc1", {cmd(), refresh_busy}, 15);
        @(negedge clk);
        chk(cmd() == 7 && refresh_busy && cke, "R4 R6 NOP in Trc2", {cmd(), refresh_busy, cke}, 31);
        @(negedge clk);
        chk(cmd() == 7 && !refresh_busy, "R7 idle after burst", {cmd(), refresh_busy}, 14);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t0, t1, npre;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cmd() == 7, "R10 reset command NOP", cmd(), 7);
        chk(!prechg_sel && cke && !refresh_busy, "R10 reset flags",
            {prechg_sel, cke, refresh_busy}, 2);

        // Table walk: R3 first latency, R2 interval per divide code
        for (int v = 0; v < 8; v++) begin
            int exp_int;
            exp_int = int'(VEC[v][15:0]);
            @(negedge clk);
            refresh_en = 1'b0;
            @(negedge clk);
            clk_sel    = VEC[v][26:24];
            cmp_value  = VEC[v][23:16];
            refresh_en = 1'b1;
            t0 = cyc;
            wait_pre(exp_int + 20, t1);
            chk(t1 - t0 == exp_int + 1, "R3 first latency", t1 - t0, exp_int + 1);
            check_burst();
            wait_pre(exp_int + 20, t0);
            chk(t0 - t1 == exp_int, "R2 R3 interval", t0 - t1, exp_int);
            check_burst();
        end

        // R1: disabled, nothing happens
        @(negedge clk);
        refresh_en = 1'b0; clk_sel = 3'd1; cmp_value = 8'd0;
        npre = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (is_pre()) npre++;
        end
        chk(npre == 0 && !refresh_busy, "R1 no refresh when disabled", npre, 0);

        // R2: stop code holds the count, restart phase costs one cycle
        cmp_value = 8'd4; refresh_en = 1'b1;
        wait_pre(50, t1);
        clk_sel = 3'd0;
        npre = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (is_pre()) npre++;
        end
        chk(npre == 0, "R2 stopped counter issues nothing", npre, 0);
        clk_sel = 3'd1;
        wait_pre(100, t0);
        chk(t0 - t1 == 2 * 5 + 20 + 1, "R2 hold extends interval", t0 - t1, 31);
        repeat (6) @(negedge clk);

        // R8/R9: matches pile up while bus busy, collapse to one burst
        refresh_en = 1'b0;
        @(negedge clk);
        bus_idle = 1'b0; clk_sel = 3'd1; cmp_value = 8'd0; refresh_en = 1'b1;
        npre = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!ras_n || !cas_n || !we_n) npre++;
        end
        chk(npre == 0, "R8 no command while bus busy", npre, 0);
        chk(refresh_busy == 1'b1, "R7 busy while request pending", refresh_busy, 1);
        bus_idle = 1'b1; refresh_en = 1'b0;
        @(negedge clk);
        chk(is_pre(), "R8 R9 burst starts once bus idle", cmd(), 2);
        check_burst();
        npre = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (is_pre()) npre++;
        end
        chk(npre == 0, "R9 single burst for many matches", npre, 0);

        summary();
        $finish;
    end

endmodule